// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block is the register-side front end of a SHA-family hashing engine. Software drives it through a 32-bit register bus. The bus reaches a control word, a byte-count register, an eight-word window onto the chaining state and a 64-byte data window. Words written anywhere in the data window are collected in order into a 512-bit message block. When sixteen words are present, the block is offered to a compression core over a valid/ready handshake. The core later returns the updated chaining state, which replaces the state held here.

On request, the front end finishes the message itself. It appends the marker word and the zero fill, then places the 64-bit message length in bits in the last two words. When the data does not leave room for the length, it sends a second block. The state window can be read and written at any time between blocks, so a hash in progress can be saved and later restored. One control word holds the start request, the finish request, the algorithm choice, the byte order of the state window, the data-window read mode and two interrupt enables.

Top module: `hash_regfront`

## Requirements
- R1: After reset, the control word and the byte count read 0, `blk_valid_o`, `irq0_o` and `irq1_o` are low, and `ready_o` is high.
- R2: A control write with bit 0 set, made while the busy flag is 0, loads the initial state of the chosen algorithm and clears the message buffer and the byte count. Algorithm field bits 5:4 select SHA-256 (0), SHA-224 (1) or SHA-1 (2 or 3). The same write made while busy is ignored.
- R3: State window reads (byte offsets 0x40 to 0x5C, word index = offset bits 4:2) return 0 above the last valid output word. SHA-256 has 8 valid words, SHA-224 has 7 and SHA-1 has 5.
- R4: Control bit 3 sets the byte order of the state window. With bit 3 = 1, a state word is read and written as stored, with the first digest byte in bits 31:24. With bit 3 = 0, the four bytes are reversed in both directions.
- R5: A write to any byte offset from 0x80 to 0xBF stores the next message word in arrival order. On `blk_data_o`, message word k sits at bits 511-32k down to 480-32k.
- R6: Once sixteen words are buffered, `blk_valid_o` rises and stays high with stable data until `blk_ready_i`. Until then, data-window writes see `ready_o` low, while other accesses complete.
- R7: `blk_state_o` presents the current chaining state (word 0 in the top 32 bits). A pulse on `st_valid_i` replaces that state with `st_data_i`, and the new state is readable through the state window.
- R8: Writes to the state window replace the chaining state word at that index, so a saved state can be restored.
- R9: A control write with bit 1 set starts finalisation. With at most 13 words buffered, one block is sent: the data, then 0x80000000, then zeros, with word 14 holding the upper and word 15 the lower half of the message length in bits.
- R10: With 14 or 15 words buffered at finalisation, the first block carries the data, 0x80000000 and zeros. A second block of zeros carries the length in words 14 and 15.
- R11: The byte-count register (offset 0x04) changes only when finalisation completes, when it takes the total bytes written since start, or when a start clears it.
- R12: Control bit 0 reads 1 while a block is buffered, in flight or being finalised. Bit 1 reads 1 from the finish request until the final state has returned, then 0.
- R13: When finalisation completes, `irq0_o` pulses for one cycle if control bit 2 is set, and `irq1_o` pulses for one cycle if control bit 10 is set.
- R14: With control bit 9 = 1, data-window reads return the buffered word at index offset bits 5:2. With bit 9 = 0 they return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Bus write enable |
| addr_i | input | ADDR_W | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, valid in the request cycle |
| ready_o | output | 1 | Bus access completes at this edge |
| blk_valid_o | output | 1 | Message block offered to the core |
| blk_ready_i | input | 1 | Core accepts the block |
| blk_data_o | output | 512 | Message block, word 0 in the top bits |
| blk_state_o | output | 256 | Current chaining state, word 0 in the top bits |
| st_valid_i | input | 1 | Core returns the updated state |
| st_data_i | input | 256 | Updated state from the core |
| irq0_o | output | 1 | Completion pulse, first enable |
| irq1_o | output | 1 | Completion pulse, second enable |

## Verification
The bench goes after both padding boundaries. A block with three data words must receive one padded block. A design that miscounts room would emit a spurious second block. With fourteen words buffered, a design that squeezes the length in would overwrite the marker word or lose the length block. The stall case holds the core off and probes `ready_o` on a data write, which catches a front end that overwrites a pending block. Save and restore through the reversed byte order, the SHA-224 and SHA-1 word limits, and a start issued while busy each expose a swap applied on one path only, a wrong word count, or a start that wipes a stream in flight.

// File: rtl/hash_fe_pkg.sv
package hash_fe_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int ST_WORDS  = 8;
  localparam int FILL_W    = $clog2(BLK_WORDS + 1);
  localparam int BIDX_W    = $clog2(BLK_WORDS);
  localparam int SIDX_W    = $clog2(ST_WORDS);
  localparam int LEN_ROOM  = BLK_WORDS - 3;  // last fill that still fits marker + length

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ALG_S256 = 2'd0,
    ALG_S224 = 2'd1,
    ALG_S1A  = 2'd2,
    ALG_S1B  = 2'd3
  } alg_e;

  typedef enum logic [1:0] {
    PAD_NONE = 2'd0,
    PAD_MARK = 2'd1,
    PAD_LEN  = 2'd2
  } pad_e;

  localparam word_t PAD_WORD = 32'h8000_0000;

  function automatic word_t bswap(word_t w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic word_t init_word(alg_e a, logic [SIDX_W-1:0] i);
    word_t r;
    r = '0;
    case (a)
      ALG_S256: case (i)
        3'd0: r = 32'h6a09e667; 3'd1: r = 32'hbb67ae85;
        3'd2: r = 32'h3c6ef372; 3'd3: r = 32'ha54ff53a;
        3'd4: r = 32'h510e527f; 3'd5: r = 32'h9b05688c;
        3'd6: r = 32'h1f83d9ab; default: r = 32'h5be0cd19;
      endcase
      ALG_S224: case (i)
        3'd0: r = 32'hc1059ed8; 3'd1: r = 32'h367cd507;
        3'd2: r = 32'h3070dd17; 3'd3: r = 32'hf70e5939;
        3'd4: r = 32'hffc00b31; 3'd5: r = 32'h68581511;
        3'd6: r = 32'h64f98fa7; default: r = 32'hbefa4fa4;
      endcase
      default: case (i)
        3'd0: r = 32'h67452301; 3'd1: r = 32'hefcdab89;
        3'd2: r = 32'h98badcfe; 3'd3: r = 32'h10325476;
        3'd4: r = 32'hc3d2e1f0; default: r = '0;
      endcase
    endcase
    return r;
  endfunction

  function automatic logic [SIDX_W:0] out_words(alg_e a);
    case (a)
      ALG_S256: return (SIDX_W+1)'(8);
      ALG_S224: return (SIDX_W+1)'(7);
      default:  return (SIDX_W+1)'(5);
    endcase
  endfunction
endpackage

// File: rtl/hash_fe_buf.sv
module hash_fe_buf
  import hash_fe_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        push_i,
  input  word_t                       push_data_i,
  input  pad_e                        pad_i,
  input  logic [63:0]                 len_bits_i,
  input  logic                        take_i,
  output word_t [BLK_WORDS-1:0]       words_o,
  output logic  [FILL_W-1:0]          fill_o,
  output logic                        full_o
);
  word_t             buf_q [BLK_WORDS];
  logic [FILL_W-1:0] fill_q;
  logic [BIDX_W-1:0] wr_idx;

  assign wr_idx = fill_q[BIDX_W-1:0];
  assign full_o = (fill_q == FILL_W'(BLK_WORDS));
  assign fill_o = fill_q;

  // taken block is zeroed so padding only needs the marker and length words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int k = 0; k < BLK_WORDS; k++) buf_q[k] <= '0;
    end else if (clr_i || take_i) begin
      fill_q <= '0;
      for (int k = 0; k < BLK_WORDS; k++) buf_q[k] <= '0;
    end else if (pad_i == PAD_MARK) begin
      buf_q[wr_idx] <= PAD_WORD;
      if (fill_q <= FILL_W'(LEN_ROOM)) begin
        buf_q[BLK_WORDS-2] <= len_bits_i[63:32];
        buf_q[BLK_WORDS-1] <= len_bits_i[31:0];
      end
      fill_q <= FILL_W'(BLK_WORDS);
    end else if (pad_i == PAD_LEN) begin
      buf_q[BLK_WORDS-2] <= len_bits_i[63:32];
      buf_q[BLK_WORDS-1] <= len_bits_i[31:0];
      fill_q             <= FILL_W'(BLK_WORDS);
    end else if (push_i && !full_o) begin
      buf_q[wr_idx] <= push_data_i;
      fill_q        <= fill_q + 1'b1;
    end
  end

  for (genvar k = 0; k < BLK_WORDS; k++) begin : g_out
    assign words_o[k] = buf_q[k];
  end
endmodule

// File: rtl/hash_fe_state.sv
module hash_fe_state
  import hash_fe_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   init_i,
  input  alg_e                   alg_i,
  input  logic                   wr_i,
  input  logic [SIDX_W-1:0]      wr_idx_i,
  input  word_t                  wr_data_i,
  input  logic                   load_i,
  input  word_t [ST_WORDS-1:0]   load_data_i,
  output word_t [ST_WORDS-1:0]   st_o
);
  for (genvar k = 0; k < ST_WORDS; k++) begin : g_word
    word_t w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   w_q <= '0;
      else if (init_i)                               w_q <= init_word(alg_i, SIDX_W'(k));
      else if (load_i)                               w_q <= load_data_i[k];
      else if (wr_i && wr_idx_i == SIDX_W'(k))       w_q <= wr_data_i;
    end
    assign st_o[k] = w_q;
  end
endmodule

// File: rtl/hash_fe_ctrl.sv
module hash_fe_ctrl
  import hash_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fin_req_i,
  input  logic              full_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic              blk_ready_i,
  input  logic              st_valid_i,
  output logic              blk_valid_o,
  output logic              take_o,
  output pad_e              pad_o,
  output logic              fin_active_o,
  output logic              busy_o,
  output logic              done_o
);
  typedef enum logic [1:0] {C_IDLE, C_SEND, C_WAIT} core_st_e;
  typedef enum logic [1:0] {F_OFF, F_MARK, F_LEN, F_DRAIN} fin_st_e;

  core_st_e c_q, c_d;
  fin_st_e  f_q, f_d;

  always_comb begin
    c_d = c_q;
    case (c_q)
      C_IDLE:  if (full_i)      c_d = C_SEND;
      C_SEND:  if (blk_ready_i) c_d = C_WAIT;
      default: if (st_valid_i)  c_d = C_IDLE;
    endcase
  end

  assign blk_valid_o = (c_q == C_SEND);
  assign take_o      = (c_q == C_SEND) && blk_ready_i;

  always_comb begin
    f_d    = f_q;
    pad_o  = PAD_NONE;
    done_o = 1'b0;
    case (f_q)
      F_OFF: if (fin_req_i) f_d = F_MARK;
      F_MARK: if (!full_i) begin
        pad_o = PAD_MARK;
        f_d   = (fill_i > FILL_W'(LEN_ROOM)) ? F_LEN : F_DRAIN;
      end
      F_LEN: if (!full_i) begin
        pad_o = PAD_LEN;
        f_d   = F_DRAIN;
      end
      default: if (c_q == C_IDLE && !full_i) begin
        done_o = 1'b1;
        f_d    = F_OFF;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= C_IDLE;
      f_q <= F_OFF;
    end else begin
      c_q <= c_d;
      f_q <= f_d;
    end
  end

  assign fin_active_o = (f_q != F_OFF);
  assign busy_o       = (c_q != C_IDLE) || full_i || fin_active_o;
endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
  import hash_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic                          ready_o,
  output logic                          blk_valid_o,
  input  logic                          blk_ready_i,
  output logic [BLK_WORDS*WORD_W-1:0]   blk_data_o,
  output logic [ST_WORDS*WORD_W-1:0]    blk_state_o,
  input  logic                          st_valid_i,
  input  logic [ST_WORDS*WORD_W-1:0]    st_data_i,
  output logic                          irq0_o,
  output logic                          irq1_o
);
  localparam logic [7:0] OFF_CTL = 8'h00;
  localparam logic [7:0] OFF_CNT = 8'h04;

  logic [7:0] a8;
  logic       hi_ok, sel_ctl, sel_cnt, sel_st, sel_dat;
  logic       wr_acc, ctl_wr, start_acc, fin_acc, push, st_wr, stall;

  logic       irq0_en_q, irq1_en_q, be_q, fifo_q;
  alg_e       alg_q;
  logic [CNT_W-1:0] run_cnt_q, cnt_q;
  logic       irq0_q, irq1_q;

  word_t [BLK_WORDS-1:0] words;
  word_t [ST_WORDS-1:0]  st_w, st_in;
  logic [FILL_W-1:0]     fill;
  logic                  full, take, fin_active, busy, done;
  pad_e                  pad;
  logic [63:0]           len_bits;
  logic [SIDX_W-1:0]     s_idx;
  logic [BIDX_W-1:0]     d_idx;

  assign a8      = addr_i[7:0];
  assign hi_ok   = ((addr_i >> 8) == '0);
  assign sel_ctl = hi_ok && (a8 == OFF_CTL);
  assign sel_cnt = hi_ok && (a8 == OFF_CNT);
  assign sel_st  = hi_ok && (a8[7:5] == 3'b010);
  assign sel_dat = hi_ok && (a8[7:6] == 2'b10);
  assign s_idx   = a8[2 +: SIDX_W];
  assign d_idx   = a8[2 +: BIDX_W];

  assign stall   = req_i && we_i && sel_dat && (full || fin_active);
  assign ready_o = !stall;
  assign wr_acc  = req_i && we_i && ready_o;
  assign ctl_wr  = wr_acc && sel_ctl;
  assign start_acc = ctl_wr && wdata_i[0] && !busy;
  assign fin_acc   = ctl_wr && wdata_i[1] && !wdata_i[0] && !fin_active;
  assign push      = wr_acc && sel_dat;
  assign st_wr     = wr_acc && sel_st;
  assign len_bits  = 64'(run_cnt_q) << 3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq0_en_q <= 1'b0;
      irq1_en_q <= 1'b0;
      be_q      <= 1'b0;
      fifo_q    <= 1'b0;
      alg_q     <= ALG_S256;
    end else if (ctl_wr) begin
      irq0_en_q <= wdata_i[2];
      be_q      <= wdata_i[3];
      alg_q     <= alg_e'(wdata_i[5:4]);
      fifo_q    <= wdata_i[9];
      irq1_en_q <= wdata_i[10];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_q <= '0;
      cnt_q     <= '0;
      irq0_q    <= 1'b0;
      irq1_q    <= 1'b0;
    end else begin
      irq0_q <= done && irq0_en_q;
      irq1_q <= done && irq1_en_q;
      if (start_acc) begin
        run_cnt_q <= '0;
        cnt_q     <= '0;
      end else begin
        if (push) run_cnt_q <= run_cnt_q + CNT_W'(WORD_W / 8);
        if (done) cnt_q     <= run_cnt_q;
      end
    end
  end

  assign irq0_o = irq0_q;
  assign irq1_o = irq1_q;

  hash_fe_buf u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_acc),
    .push_i      (push),
    .push_data_i (wdata_i),
    .pad_i       (pad),
    .len_bits_i  (len_bits),
    .take_i      (take),
    .words_o     (words),
    .fill_o      (fill),
    .full_o      (full)
  );

  hash_fe_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fin_req_i    (fin_acc),
    .full_i       (full),
    .fill_i       (fill),
    .blk_ready_i  (blk_ready_i),
    .st_valid_i   (st_valid_i),
    .blk_valid_o  (blk_valid_o),
    .take_o       (take),
    .pad_o        (pad),
    .fin_active_o (fin_active),
    .busy_o       (busy),
    .done_o       (done)
  );

  hash_fe_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (start_acc),
    .alg_i       (alg_e'(wdata_i[5:4])),
    .wr_i        (st_wr),
    .wr_idx_i    (s_idx),
    .wr_data_i   (be_q ? wdata_i : bswap(wdata_i)),
    .load_i      (st_valid_i),
    .load_data_i (st_in),
    .st_o        (st_w)
  );

  // word 0 travels in the most significant lane
  for (genvar k = 0; k < BLK_WORDS; k++) begin : g_blk
    assign blk_data_o[(BLK_WORDS-1-k)*WORD_W +: WORD_W] = words[k];
  end
  for (genvar k = 0; k < ST_WORDS; k++) begin : g_st
    assign blk_state_o[(ST_WORDS-1-k)*WORD_W +: WORD_W] = st_w[k];
    assign st_in[k] = st_data_i[(ST_WORDS-1-k)*WORD_W +: WORD_W];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctl) begin
      rdata_o = {21'b0, irq1_en_q, fifo_q, 3'b0, alg_q, be_q, irq0_en_q, fin_active, busy};
    end else if (sel_cnt) begin
      rdata_o = 32'(cnt_q);
    end else if (sel_st) begin
      if ({1'b0, s_idx} < out_words(alg_q)) rdata_o = be_q ? st_w[s_idx] : bswap(st_w[s_idx]);
    end else if (sel_dat) begin
      if (fifo_q) rdata_o = words[d_idx];
    end
  end
endmodule

// File: rtl/hash_regfront_chk.sv
module hash_regfront_chk
  import hash_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic                        ready_o,
  input logic                        blk_valid_o,
  input logic                        blk_ready_i,
  input logic [BLK_WORDS*WORD_W-1:0] blk_data_o,
  input logic                        irq0_o,
  input logic                        irq1_o,
  input logic                        fin_active_i,
  input logic                        start_acc_i,
  input logic [CNT_W-1:0]            cnt_i
);
  logic data_wr;
  assign data_wr = req_i && we_i && (addr_i[7:6] == 2'b10);

  p_valid_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o && !blk_ready_i |=> blk_valid_o && $stable(blk_data_o));

  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && blk_valid_o |-> !ready_o);

  p_irq0_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_o |=> !irq0_o);

  p_irq1_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |=> !irq1_o);

  p_irq_after_fin_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq0_o || irq1_o) |-> !fin_active_i && $past(fin_active_i));

  p_cnt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> $past(fin_active_i) || $past(start_acc_i));
endmodule

bind hash_regfront hash_regfront_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .ready_o      (ready_o),
  .blk_valid_o  (blk_valid_o),
  .blk_ready_i  (blk_ready_i),
  .blk_data_o   (blk_data_o),
  .irq0_o       (irq0_o),
  .irq1_o       (irq1_o),
  .fin_active_i (fin_active),
  .start_acc_i  (start_acc),
  .cnt_i        (cnt_q)
);

// File: tb/hash_regfront_test.sv
module hash_regfront_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic         ready, blk_valid, blk_ready, st_valid, irq0, irq1;
  logic [511:0] blk_data;
  logic [255:0] blk_state, st_data;

  always #2 clk = ~clk;  // 250 MHz

  hash_regfront uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .blk_valid_o(blk_valid), .blk_ready_i(blk_ready), .blk_data_o(blk_data),
    .blk_state_o(blk_state), .st_valid_i(st_valid), .st_data_i(st_data),
    .irq0_o(irq0), .irq1_o(irq1)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] bsw(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] bw(logic [511:0] b, int k);
    return b[511-32*k -: 32];
  endfunction
  function automatic logic [31:0] sw(logic [255:0] s, int k);
    return s[255-32*k -: 32];
  endfunction
  function automatic logic [255:0] mix(logic [255:0] s, logic [511:0] b);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = sw(s, i) + (bw(b, i) ^ bw(b, 15 - i));
    return r;
  endfunction

  // stand-in compression core
  logic core_go = 1'b0, core_busy = 1'b0;
  int   nblk = 0;
  logic [511:0] blk_log [4];
  logic [255:0] stl_log [4];
  assign blk_ready = core_go && !core_busy;

  initial begin
    st_valid = 1'b0;
    st_data  = '0;
    forever begin
      @(posedge clk);
      if (blk_valid && blk_ready) begin
        blk_log[nblk % 4] = blk_data;
        stl_log[nblk % 4] = blk_state;
        st_data = mix(blk_state, blk_data);
        @(negedge clk); core_busy = 1'b1;
        @(negedge clk); st_valid = 1'b1;
        @(negedge clk); st_valid = 1'b0; core_busy = 1'b0;
        nblk++;
      end
    end
  end

  int irq0_cnt = 0, irq1_cnt = 0;
  always @(posedge clk) begin
    if (irq0) irq0_cnt++;
    if (irq1) irq1_cnt++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1; d = rdata;
    @(posedge clk); #1; req = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    c = 32'h3;
    while (c[1:0] != 2'b00) bus_rd(8'h00, c);
  endtask

  logic [31:0] exp_st [8];
  logic [31:0] exp_blk [16];
  logic [31:0] saved [8];

  task automatic check_block(input int idx, input string tag);
    logic [255:0] s;
    for (int k = 0; k < 16; k++) chk(tag, bw(blk_log[idx], k), exp_blk[k]);
    for (int k = 0; k < 8; k++) chk("R7 state to core", sw(stl_log[idx], k), exp_st[k]);
    s = '0;
    for (int k = 0; k < 8; k++) s[255-32*k -: 32] = exp_st[k];
    s = mix(s, blk_log[idx]);
    for (int k = 0; k < 8; k++) exp_st[k] = sw(s, k);
  endtask

  task automatic set_iv256();
    exp_st = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
               32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  endtask

  // {alg[37:36], byte order[35], word index[34:32], expected read}
  localparam logic [37:0] VEC [9] = '{
    {2'd0, 1'b1, 3'd0, 32'h6a09e667},
    {2'd0, 1'b0, 3'd0, 32'h67e6096a},
    {2'd0, 1'b1, 3'd7, 32'h5be0cd19},
    {2'd1, 1'b1, 3'd0, 32'hc1059ed8},
    {2'd1, 1'b1, 3'd6, 32'h64f98fa7},
    {2'd1, 1'b1, 3'd7, 32'h00000000},
    {2'd2, 1'b1, 3'd4, 32'hc3d2e1f0},
    {2'd3, 1'b1, 3'd5, 32'h00000000},
    {2'd3, 1'b0, 3'd1, 32'h89abcdef}
  };

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_rd(8'h00, rd); chk("R1 ctl", rd, 32'h0);
    bus_rd(8'h04, rd); chk("R1 cnt", rd, 32'h0);
    chk("R1 valid", {31'b0, blk_valid}, 32'h0);
    chk("R1 irq", {30'b0, irq1, irq0}, 32'h0);
    chk("R1 ready", {31'b0, ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 initial state per algorithm and byte order
    foreach (VEC[i]) begin
      bus_wr(8'h00, 32'h1 | (32'(VEC[i][35]) << 3) | (32'(VEC[i][37:36]) << 4));
      bus_rd(8'h40 + 8'(VEC[i][34:32]) * 8'd4, rd);
      chk("R2/R3/R4 state window", rd, VEC[i][31:0]);
    end

    // stream of 16 words to scattered offsets, core held off
    bus_wr(8'h00, 32'h1 | 32'h4 | 32'h8 | 32'h200);
    set_iv256();
    bus_rd(8'h00, rd); chk("R12 idle after start", rd, 32'h20C);
    for (int k = 0; k < 16; k++) begin
      exp_blk[k] = 32'hA000_0000 + 32'h0101_0101 * 32'(k);
      bus_wr(8'h80 + 8'(((k * 7) % 16) * 4), exp_blk[k]);
      if (k == 9) begin
        bus_rd(8'h8C, rd); chk("R14 readback", rd, exp_blk[3]);
        bus_rd(8'h04, rd); chk("R11 count before final", rd, 32'h0);
      end
    end
    repeat (2) @(negedge clk);
    chk("R6 valid raised", {31'b0, blk_valid}, 32'h1);
    req = 1'b1; we = 1'b1; addr = 8'hA4; wdata = 32'hDEAD_BEEF; #1;
    chk("R6 data write stalled", {31'b0, ready}, 32'h0);
    we = 1'b0; addr = 8'h00; #1;
    chk("R6 control read proceeds", {31'b0, ready}, 32'h1);
    chk("R12 busy while pending", rdata & 32'h3, 32'h1);
    @(negedge clk); req = 1'b0;
    core_go = 1'b1;
    while (nblk < 1) @(negedge clk);
    check_block(0, "R5 block order");
    wait_idle();
    for (int k = 0; k < 8; k++) begin
      bus_rd(8'h40 + 8'(k * 4), rd); chk("R7 returned state", rd, exp_st[k]);
    end

    // three words then final: single padded block
    for (int k = 0; k < 3; k++) bus_wr(8'hB0, 32'h5500_0000 + 32'(k));
    bus_wr(8'h00, 32'h2 | 32'h4 | 32'h8 | 32'h200);
    bus_rd(8'h00, rd); chk("R12 final flag set", rd & 32'h3, 32'h3);
    for (int k = 0; k < 16; k++) exp_blk[k] = 32'h0;
    for (int k = 0; k < 3; k++) exp_blk[k] = 32'h5500_0000 + 32'(k);
    exp_blk[3]  = 32'h8000_0000;
    exp_blk[15] = 32'd608;
    wait_idle();
    chk("R9 one block", 32'(nblk), 32'd2);
    check_block(1, "R9 padding");
    for (int k = 0; k < 8; k++) begin
      bus_rd(8'h40 + 8'(k * 4), rd); chk("R7 digest", rd, exp_st[k]);
      saved[k] = rd;
    end
    bus_rd(8'h04, rd); chk("R11 count after final", rd, 32'd76);
    chk("R13 irq0 pulse", 32'(irq0_cnt), 32'd1);
    chk("R13 irq1 gated", 32'(irq1_cnt), 32'd0);

    // restore through reversed byte order, 14 words then final: two blocks
    bus_wr(8'h00, 32'h1 | 32'h400);
    bus_rd(8'h04, rd); chk("R2 start clears count", rd, 32'h0);
    for (int k = 0; k < 8; k++) bus_wr(8'h40 + 8'(k * 4), bsw(saved[k]));
    for (int k = 0; k < 8; k++) exp_st[k] = saved[k];
    bus_rd(8'h48, rd); chk("R8 restored word", rd, bsw(saved[2]));
    for (int k = 0; k < 14; k++) begin
      exp_blk[k] = 32'h3C00_0000 ^ 32'(k * 13);
      bus_wr(8'h80 + 8'(k * 4), exp_blk[k]);
    end
    bus_rd(8'h84, rd); chk("R14 write-only read", rd, 32'h0);
    bus_wr(8'h00, 32'h2 | 32'h400);
    exp_blk[14] = 32'h8000_0000;
    exp_blk[15] = 32'h0;
    wait_idle();
    chk("R10 two blocks", 32'(nblk), 32'd4);
    check_block(2, "R10 marker block");
    for (int k = 0; k < 16; k++) exp_blk[k] = 32'h0;
    exp_blk[15] = 32'd448;
    check_block(3, "R10 length block");
    for (int k = 0; k < 8; k++) begin
      bus_rd(8'h40 + 8'(k * 4), rd); chk("R4 reversed digest", rd, bsw(exp_st[k]));
    end
    bus_rd(8'h04, rd); chk("R11 second count", rd, 32'd56);
    chk("R13 irq1 pulse", 32'(irq1_cnt), 32'd1);
    chk("R13 irq0 gated", 32'(irq0_cnt), 32'd1);

    // start while busy is ignored
    core_go = 1'b0;
    bus_wr(8'h00, 32'h1 | 32'h8);
    for (int k = 0; k < 16; k++) bus_wr(8'h80, 32'(k));
    bus_wr(8'h00, 32'h1 | 32'h8 | 32'h20);
    bus_rd(8'h40, rd); chk("R2 start ignored while busy", rd, 32'h6a09e667);
    core_go = 1'b1;
    wait_idle();

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    bus_rd(8'h00, rd); chk("R1 ctl after reset", rd, 32'h0);
    chk("R1 valid after reset", {31'b0, blk_valid}, 32'h0);
    finish_run();
  end
endmodule